// File: doc/BRIEF.md
# Checkerboard Conditioning Write-Verify Sequencer

This block runs a byte-wide nonvolatile memory through a conditioning run without help from a processor. After a start pulse it fills every location of the array with a checkerboard byte pattern and then reads the whole array back, comparing each byte against the value it wrote. It then fills the array again with the bitwise complement and verifies it. It repeats this alternation for a programmable number of fills. Each single-byte write is followed by a fixed idle window, given in clock cycles, that covers the memory's self-timed erase/write cycle.

The start phase is selected per part by an input, so half of a population can begin on the plain checkerboard and the other half on its complement. When the conditioning fills are finished, the sequencer performs one more fill whose phase is the inverse of the last conditioning fill. That fill is verified like the others. In this way no cell ever holds more charge than one write leaves behind.

Mismatches are counted in a saturating counter. The address and the read data of the first mismatch are held so they can be read out after the run.

Top module: `ckbd_condition_seq`

## Requirements
- R1: The write data is 8'h55 when (address bit 0 XOR current phase) is 0, and 8'hAA when it is 1.
- R2: The first fill uses the phase given by `startInv`, sampled at start. Each later fill uses the complement of the phase of the fill before it.
- R3: The run makes exactly NUM_PASS conditioning fills and then one closing fill whose phase is the inverse of the last conditioning fill, for NUM_PASS+1 fills in total. Each fill writes addresses 0 to 2**ADDR_W-1 in ascending order.
- R4: Each write is a single cycle with `memCe` and `memWe` high. Within a fill, the next write follows exactly WAIT_CYC+1 cycles later.
- R5: After every fill, and only once all of its writes are done, every address is read in ascending order, one per cycle, with `memCe` and `memOe` high. `memRdData` is compared on the clock edge one cycle after the read cycle.
- R6: `errCount` rises by one for each byte that reads back different from the value written. It saturates at its all-ones value and never wraps.
- R7: `firstFailAddr` and `firstFailData` capture the address and the read data of the first mismatch of a run. They hold those values until the next start, which clears them to zero together with `errCount`.
- R8: `busy` goes high in the cycle after a start is accepted and stays high until `done` rises. `done` stays high until the next start. A start pulse while `busy` is high is ignored.
- R9: After reset `busy`, `done`, `memWe`, `memOe` and `errCount` are all zero.
- R10: `memWe` and `memOe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| startInv | input | 1 | Phase of the first fill: 0 plain checkerboard, 1 complement |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| errCount | output | ERR_W | Saturating mismatch count |
| firstFailAddr | output | ADDR_W | Address of first mismatch |
| firstFailData | output | 8 | Data read at first mismatch |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, valid one cycle after a read strobe |
| memCe | output | 1 | Memory chip enable |
| memWe | output | 1 | Memory write strobe |
| memOe | output | 1 | Memory output enable |

## Verification
On every cycle the assertions check several rules. Write and read strobes never overlap. A write strobe never lasts two cycles. The mismatch counter only steps by one or sticks at its ceiling. The first-failure record stays frozen once it is captured. A start is never accepted while busy, and `done` holds until a restart. Only the bench scenarios can show the whole-run behaviour, using a memory model with injectable read faults. That behaviour covers the phase sequence across fills, the closing-fill inversion left in the array, the exact write spacing, read-back ordering after each fill, and exact error totals and first-failure capture.

// File: rtl/ckbd_pkg.sv
package ckbd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WAIT_WR,
    ST_VERIFY,
    ST_NEXT_PASS,
    ST_FINAL_WRITE,
    ST_DONE
  } seqState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic clrAll;    // restart: clear counters and results, load start phase
    logic addrInc;
    logic addrClr;
    logic waitClr;
    logic waitInc;
    logic passInc;   // count a finished fill and flip the phase
    logic setFinal;  // mark the closing fill
    logic wrEn;
    logic rdEn;
  } seqCtl_t;

  localparam logic [7:0] PAT_EVEN = 8'h55;
  localparam logic [7:0] PAT_ODD  = 8'hAA;

endpackage

// File: rtl/ckbd_ctrl.sv
module ckbd_ctrl
  import ckbd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    addrLast,
  input  logic    waitDone,
  input  logic    passLast,
  input  logic    finalFlag,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done
);

  seqState_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    ctl    = '0;
    stNext = st;
    case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctl.clrAll = 1'b1;
          stNext     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctl.wrEn    = 1'b1;
        ctl.waitClr = 1'b1;
        stNext      = ST_WAIT_WR;
      end
      ST_WAIT_WR: begin
        if (waitDone) begin
          if (addrLast) begin
            ctl.addrClr = 1'b1;
            stNext      = ST_VERIFY;
          end else begin
            ctl.addrInc = 1'b1;
            stNext      = ST_WRITE;
          end
        end else begin
          ctl.waitInc = 1'b1;
        end
      end
      ST_VERIFY: begin
        ctl.rdEn = 1'b1;
        if (addrLast) begin
          ctl.addrClr = 1'b1;
          stNext      = ST_NEXT_PASS;
        end else begin
          ctl.addrInc = 1'b1;
        end
      end
      ST_NEXT_PASS: begin
        if (finalFlag) begin
          stNext = ST_DONE;
        end else begin
          ctl.passInc = 1'b1;
          stNext      = passLast ? ST_FINAL_WRITE : ST_WRITE;
        end
      end
      ST_FINAL_WRITE: begin
        ctl.setFinal = 1'b1;
        stNext       = ST_WRITE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign busy = (st != ST_IDLE) && (st != ST_DONE);
  assign done = (st == ST_DONE);

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.clrAll) else $error("start accepted while busy");  // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done) else $error("done dropped without start");  // R8

endmodule

// File: rtl/ckbd_dpath.sv
module ckbd_dpath
  import ckbd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int NUM_PASS = 220,
  parameter int WAIT_CYC = 500000,
  parameter int ERR_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              startInv,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wrData,
  output logic              addrLast,
  output logic              waitDone,
  output logic              passLast,
  output logic              finalFlag,
  output logic [ERR_W-1:0]  errCnt,
  output logic [ADDR_W-1:0] firstFailAddr,
  output logic [7:0]        firstFailData
);

  localparam int WAIT_W = $clog2(WAIT_CYC + 1);
  localparam int PASS_W = $clog2(NUM_PASS + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [WAIT_W-1:0] waitCnt;
  logic [PASS_W-1:0] passCnt;
  logic              phase;
  logic              failSeen;
  logic              cmpValid;
  logic [ADDR_W-1:0] cmpAddr;
  logic [7:0]        cmpExp;
  logic              mismatch;

  assign addrLast = &addr;
  assign waitDone = (waitCnt == WAIT_W'(WAIT_CYC - 1));
  assign passLast = (passCnt == PASS_W'(NUM_PASS - 1));
  assign wrData   = (addr[0] ^ phase) ? PAT_ODD : PAT_EVEN;
  assign mismatch = cmpValid && (memRdData != cmpExp);

  // sequencing counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr      <= '0;
      waitCnt   <= '0;
      passCnt   <= '0;
      phase     <= 1'b0;
      finalFlag <= 1'b0;
    end else if (ctl.clrAll) begin
      addr      <= '0;
      waitCnt   <= '0;
      passCnt   <= '0;
      phase     <= startInv;
      finalFlag <= 1'b0;
    end else begin
      if (ctl.addrClr)      addr <= '0;
      else if (ctl.addrInc) addr <= addr + 1'b1;
      if (ctl.waitClr)      waitCnt <= '0;
      else if (ctl.waitInc) waitCnt <= waitCnt + 1'b1;
      if (ctl.passInc) begin
        passCnt <= passCnt + 1'b1;
        phase   <= ~phase;
      end
      if (ctl.setFinal) finalFlag <= 1'b1;
    end
  end

  // read-back compare, one cycle behind the read strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid      <= 1'b0;
      cmpAddr       <= '0;
      cmpExp        <= '0;
      errCnt        <= '0;
      failSeen      <= 1'b0;
      firstFailAddr <= '0;
      firstFailData <= '0;
    end else if (ctl.clrAll) begin
      cmpValid      <= 1'b0;
      errCnt        <= '0;
      failSeen      <= 1'b0;
      firstFailAddr <= '0;
      firstFailData <= '0;
    end else begin
      cmpValid <= ctl.rdEn;
      cmpAddr  <= addr;
      cmpExp   <= wrData;
      if (mismatch) begin
        if (errCnt != ERR_MAX) errCnt <= errCnt + 1'b1;
        if (!failSeen) begin
          failSeen      <= 1'b1;
          firstFailAddr <= cmpAddr;
          firstFailData <= memRdData;
        end
      end
    end
  end

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == ERR_MAX && !ctl.clrAll) |=> errCnt == ERR_MAX)
    else $error("error counter wrapped");  // R6

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrAll |=> (errCnt == $past(errCnt)) || (errCnt == ERR_W'($past(errCnt) + 1'b1)))
    else $error("error counter jumped");  // R6

  AST_FIRST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (failSeen && !ctl.clrAll) |=> $stable(firstFailAddr) && $stable(firstFailData))
    else $error("first failure record changed");  // R7

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> !ctl.wrEn) else $error("write strobe longer than one cycle");  // R4

endmodule

// File: rtl/ckbd_condition_seq.sv
module ckbd_condition_seq
  import ckbd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int NUM_PASS = 220,
  parameter int WAIT_CYC = 500000,
  parameter int ERR_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              startInv,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  errCount,
  output logic [ADDR_W-1:0] firstFailAddr,
  output logic [7:0]        firstFailData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              memCe,
  output logic              memWe,
  output logic              memOe
);

  seqCtl_t ctl;
  logic    addrLast, waitDone, passLast, finalFlag;

  ckbd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .addrLast  (addrLast),
    .waitDone  (waitDone),
    .passLast  (passLast),
    .finalFlag (finalFlag),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  ckbd_dpath #(
    .ADDR_W   (ADDR_W),
    .NUM_PASS (NUM_PASS),
    .WAIT_CYC (WAIT_CYC),
    .ERR_W    (ERR_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .startInv      (startInv),
    .memRdData     (memRdData),
    .addr          (memAddr),
    .wrData        (memWrData),
    .addrLast      (addrLast),
    .waitDone      (waitDone),
    .passLast      (passLast),
    .finalFlag     (finalFlag),
    .errCnt        (errCount),
    .firstFailAddr (firstFailAddr),
    .firstFailData (firstFailData)
  );

  assign memWe = ctl.wrEn;
  assign memOe = ctl.rdEn;
  assign memCe = ctl.wrEn | ctl.rdEn;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memOe)) else $error("write and read strobes overlap");  // R10

endmodule

// File: tb/sim_ckbd_condition_seq.sv
module sim_ckbd_condition_seq;

  localparam int TB_ADDR_W = 3;
  localparam int DEPTH     = 1 << TB_ADDR_W;
  localparam int TB_PASS   = 4;
  localparam int TB_WAIT   = 3;
  localparam int TB_ERR_W  = 4;
  localparam int FILLS     = TB_PASS + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic startInv = 1'b0;
  logic busy, done;
  logic [TB_ERR_W-1:0]  errCount;
  logic [TB_ADDR_W-1:0] firstFailAddr, memAddr;
  logic [7:0] firstFailData, memWrData;
  logic [7:0] memRdData = 8'h00;
  logic memCe, memWe, memOe;

  always #5 clk = ~clk;

  ckbd_condition_seq #(
    .ADDR_W(TB_ADDR_W), .NUM_PASS(TB_PASS), .WAIT_CYC(TB_WAIT), .ERR_W(TB_ERR_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startInv(startInv),
    .busy(busy), .done(done), .errCount(errCount),
    .firstFailAddr(firstFailAddr), .firstFailData(firstFailData),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .memCe(memCe), .memWe(memWe), .memOe(memOe)
  );

  int checks = 0;
  int errors = 0;

  // memory model and bus monitor
  logic [7:0] mem [DEPTH];
  int   faultMode = 0;           // 0 none, 1 addresses 2 and 6, 2 every address
  logic expInv = 1'b0;
  int   cyc = 0, lastWr = 0, wrCount = 0, rdCount = 0;
  int   wrBad = 0, gapBad = 0, rdBad = 0;

  function automatic logic [7:0] expPat(input int a, input logic ph);
    return ((a[0] ^ ph) != 1'b0) ? 8'hAA : 8'h55;
  endfunction

  function automatic logic [7:0] faultMask(input logic [TB_ADDR_W-1:0] a);
    if (faultMode == 2) return 8'h10;
    if (faultMode == 1 && (a == 3'd2 || a == 3'd6)) return 8'h10;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    int f;
    cyc = cyc + 1;
    if (memCe && memWe) begin
      f = wrCount / DEPTH;
      if (memWrData != expPat(int'(memAddr), expInv ^ f[0])) wrBad = wrBad + 1;
      if (int'(memAddr) != wrCount % DEPTH) wrBad = wrBad + 1;
      if ((wrCount % DEPTH) != 0 && (cyc - lastWr) != TB_WAIT + 1) gapBad = gapBad + 1;
      lastWr  = cyc;
      wrCount = wrCount + 1;
      mem[memAddr] <= memWrData;
    end
    if (memCe && memOe) begin
      if (int'(memAddr) != rdCount % DEPTH) rdBad = rdBad + 1;
      if (wrCount != (rdCount / DEPTH + 1) * DEPTH) rdBad = rdBad + 1;
      rdCount = rdCount + 1;
      memRdData <= mem[memAddr] ^ faultMask(memAddr);
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // start a run and wait for done; optionally pulse start again mid-run
  task automatic doRun(input logic inv, input logic poke);
    int n;
    expInv  = inv;
    wrCount = 0; rdCount = 0; wrBad = 0; gapBad = 0; rdBad = 0;
    @(negedge clk);
    startInv = inv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; startInv = ~inv;     // later changes must not matter
    check(busy == 1'b1 && done == 1'b0, "R8", "busy after start", busy, 1);
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R8", "run completes", done, 1);
  endtask

  task automatic checkRunShape(input string tag);
    logic ph;
    int   bad;
    check(wrCount == FILLS * DEPTH, "R3", {tag, " write count"}, wrCount, FILLS * DEPTH);
    check(wrBad == 0, "R1", {tag, " write data/order by phase (R2)"}, wrBad, 0);
    check(gapBad == 0, "R4", {tag, " write spacing"}, gapBad, 0);
    check(rdCount == FILLS * DEPTH && rdBad == 0, "R5", {tag, " read-back order"}, rdBad, 0);
    ph  = expInv ^ TB_PASS[0];         // closing fill: inverse of last conditioning fill
    bad = 0;
    for (int a = 0; a < DEPTH; a++) if (mem[a] != expPat(a, ph)) bad++;
    check(bad == 0, "R3", {tag, " array holds closing pattern"}, bad, 0);
    check(busy == 1'b0, "R8", {tag, " busy low at done"}, busy, 0);
  endtask

  task automatic testReset();
    check(!busy && !done, "R9", "idle after reset", {busy, done}, 0);
    check(!memWe && !memOe, "R9", "no strobes after reset", {memWe, memOe}, 0);
    check(errCount == 0, "R9", "error count zero", errCount, 0);
  endtask

  task automatic testCleanRun(input logic inv);
    faultMode = 0;
    doRun(inv, 1'b1);
    checkRunShape(inv ? "inv-start" : "plain-start");
    check(errCount == 0, "R6", "clean run no errors", errCount, 0);
    check(firstFailAddr == 0 && firstFailData == 0, "R7", "cleared first-fail",
          firstFailData, 0);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8", "done held", done, 1);
  endtask

  task automatic testTwoFaults();
    faultMode = 1;
    doRun(1'b0, 1'b0);
    checkRunShape("two-fault");
    check(errCount == 2 * FILLS, "R6", "error total", errCount, 2 * FILLS);
    check(firstFailAddr == 3'd2, "R7", "first fail address", firstFailAddr, 2);
    check(firstFailData == 8'h45, "R7", "first fail data", firstFailData, 8'h45);
  endtask

  task automatic testSaturate();
    faultMode = 2;
    doRun(1'b1, 1'b0);
    check(errCount == 4'hF, "R6", "saturated count", errCount, 15);
    check(firstFailAddr == 3'd0, "R7", "first fail address", firstFailAddr, 0);
    check(firstFailData == 8'hBA, "R7", "first fail data", firstFailData, 8'hBA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCleanRun(1'b0);
    testTwoFaults();
    testCleanRun(1'b1);
    testSaturate();
    faultMode = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule